// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM out of power-up. It does not drive the memory pins itself. It sits in front of a command controller and hands that controller abstract commands: NOP, precharge-all, mode-register load and auto refresh. With each command it supplies the bank and address word that the controller places on the memory bus. The block first waits for power and clock to settle, then walks the fixed DLL-aware bring-up order. When the last mode load has been taken, it raises a done flag.

The sequencer never assumes that a command has been executed. It holds each request until the controller reports, on its state input, that it is executing that same command. It then presents NOP until the controller reports idle again. The power-up settle time, the DLL lock time and the refresh cycle time all come from a single shared counter. Each of these waits is a parameter, so a simulation can shorten them.

Top module: `ddr_init_seq`

## Requirements
- R1: A synchronous active-high `rst` sets the outputs on the next clock edge to `cmd` = NOP (code 0), `bank` = 0, `addr` = 0 and `initDone` = 0, and restarts the sequence from the beginning, even when it arrives in the middle of the sequence.
- R2: After `rst` is released, NOP is presented for exactly PWR_CYCLES+1 cycles (one idle cycle, then the power-settle wait), provided the controller is idle. The first non-NOP command then appears.
- R3: Command codes are NOP=0, PRECHARGE=1, LOAD_MODE=2, REFRESH=3. The non-NOP commands appear in exactly this order: PRECHARGE, LOAD_MODE (extended), LOAD_MODE (DLL reset), PRECHARGE, REFRESH, REFRESH, LOAD_MODE (final). No other command follows.
- R4: Every PRECHARGE is presented with `bank` = 0 and `addr` bit 10 = 1, all other bits 0 (all banks).
- R5: The extended mode load is presented with `bank` = 2'b01 and `addr` = 0 (DLL enabled, normal drive).
- R6: Both normal mode loads use `bank` = 0. In the mode word, `addr[2:0]` holds the burst length code, `addr[3]` the burst type and `addr[6:4]` the CAS latency code. The first load also sets `addr[8]` (DLL reset). The final load leaves `addr[8]` clear.
- R7: After the DLL-reset load is accepted, NOP is presented for at least DLL_CYCLES cycles. If the controller returns to idle within that time, the wait is exactly DLL_CYCLES cycles, and the second precharge follows.
- R8: After each REFRESH is accepted, NOP is presented for at least TRFC_CYCLES cycles before the next command. The wait is exactly TRFC_CYCLES if the controller is idle by then.
- R9: A requested command, with its bank and address, stays stable until `ctlState` equals that command's code. Any other non-zero `ctlState` value is ignored.
- R10: A new command is presented only after `ctlState` was 0 (idle) in the previous cycle.
- R11: `initDone` rises only after the final mode load has been accepted and the controller is idle again. It then stays high until reset, while `cmd` stays NOP with `bank` and `addr` at 0. Every NOP presentation carries zero bank and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctlState | input | 2 | Command the controller is executing (0 = idle, else command code) |
| cmd | output | 2 | Requested command code |
| bank | output | 2 | Bank address for the requested command |
| addr | output | ADDR_W | Address word for the requested command |
| initDone | output | 1 | Sequence complete |

## Verification
The controller model in the bench delays each acknowledgement by a random number of cycles. While it delays, it shows wrong non-zero state codes. A sequencer that stepped on any activity, instead of on the matching code, would skip or duplicate a command. Two loads sent back to back, with no wait for idle, would make the second load appear already acknowledged and drop it. The bench counts NOP cycles before the first precharge, after the DLL-reset load and after each refresh. These counts catch off-by-one errors in the shared counter and a counter that is not cleared between waits. A reset in the middle of the sequence must restart the full order, not resume it.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_REF  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    W_ZERO,
    W_PREALL,
    W_EXT,
    W_MODE_RST,
    W_MODE
  } word_e;

  typedef struct packed {
    logic  cntRun;   // 1: count, 0: hold counter at zero
    word_e wordSel;  // bank/address word to present
  } strobe_t;

endpackage

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int       ADDR_W      = 12,
  parameter int       PWR_CYCLES  = 20000,
  parameter int       DLL_CYCLES  = 200,
  parameter int       TRFC_CYCLES = 8,
  parameter bit [2:0] BURST_CODE  = 3'b010,
  parameter bit       BURST_TYPE  = 1'b0,
  parameter bit [2:0] CAS_CODE    = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  output logic              pwrDone,
  output logic              dllDone,
  output logic              rfcDone,
  output logic [1:0]        bank,
  output logic [ADDR_W-1:0] addr
);

  localparam int MAX_A   = (PWR_CYCLES > DLL_CYCLES) ? PWR_CYCLES : DLL_CYCLES;
  localparam int CNT_MAX = (MAX_A > TRFC_CYCLES) ? MAX_A : TRFC_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [ADDR_W-1:0] PREALL_WORD = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] DLLRST_BIT  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] MODE_WORD   =
    ADDR_W'({CAS_CODE, BURST_TYPE, BURST_CODE});

  logic [CNT_W-1:0] cnt;

  // Shared wait counter: cleared outside wait states, saturates at its top
  always_ff @(posedge clk) begin
    if (rst || !strb.cntRun)
      cnt <= '0;
    else if (cnt != CNT_W'(CNT_MAX))
      cnt <= cnt + 1'b1;
  end

  assign pwrDone = cnt >= CNT_W'(PWR_CYCLES - 1);
  assign dllDone = cnt >= CNT_W'(DLL_CYCLES - 1);
  assign rfcDone = cnt >= CNT_W'(TRFC_CYCLES - 1);

  always_comb begin
    bank = 2'b00;
    addr = '0;
    case (strb.wordSel)
      W_PREALL:   addr = PREALL_WORD;
      W_EXT:      bank = 2'b01;
      W_MODE_RST: addr = MODE_WORD | DLLRST_BIT;
      W_MODE:     addr = MODE_WORD;
      default:    addr = '0;
    endcase
  end

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ctlState,
  input  logic       pwrDone,
  input  logic       dllDone,
  input  logic       rfcDone,
  output cmd_e       cmdOut,
  output strobe_t    strb,
  output logic       initDone
);

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_NOP, S_PRE1, S_GPRE1, S_EMR, S_GEMR, S_MR1, S_DLL,
    S_PRE2, S_GPRE2, S_REF1, S_GREF1, S_REF2, S_GREF2, S_MR2, S_GMR2, S_DONE
  } state_e;

  state_e state, nxt;
  logic   ctlIdle;

  assign ctlIdle = (ctlState == CMD_NOP);

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt          = state;
    cmdOut       = CMD_NOP;
    strb.cntRun  = 1'b0;
    strb.wordSel = W_ZERO;
    case (state)
      S_IDLE:  nxt = S_PWR;
      S_PWR: begin
        strb.cntRun = 1'b1;
        if (pwrDone) nxt = S_NOP;
      end
      S_NOP:   if (ctlIdle) nxt = S_PRE1;
      S_PRE1: begin
        cmdOut = CMD_PRE;  strb.wordSel = W_PREALL;
        if (ctlState == CMD_PRE) nxt = S_GPRE1;
      end
      S_GPRE1: if (ctlIdle) nxt = S_EMR;
      S_EMR: begin
        cmdOut = CMD_LOAD; strb.wordSel = W_EXT;
        if (ctlState == CMD_LOAD) nxt = S_GEMR;
      end
      S_GEMR:  if (ctlIdle) nxt = S_MR1;
      S_MR1: begin
        cmdOut = CMD_LOAD; strb.wordSel = W_MODE_RST;
        if (ctlState == CMD_LOAD) nxt = S_DLL;
      end
      S_DLL: begin
        strb.cntRun = 1'b1;
        if (dllDone && ctlIdle) nxt = S_PRE2;
      end
      S_PRE2: begin
        cmdOut = CMD_PRE;  strb.wordSel = W_PREALL;
        if (ctlState == CMD_PRE) nxt = S_GPRE2;
      end
      S_GPRE2: if (ctlIdle) nxt = S_REF1;
      S_REF1: begin
        cmdOut = CMD_REF;
        if (ctlState == CMD_REF) nxt = S_GREF1;
      end
      S_GREF1: begin
        strb.cntRun = 1'b1;
        if (rfcDone && ctlIdle) nxt = S_REF2;
      end
      S_REF2: begin
        cmdOut = CMD_REF;
        if (ctlState == CMD_REF) nxt = S_GREF2;
      end
      S_GREF2: begin
        strb.cntRun = 1'b1;
        if (rfcDone && ctlIdle) nxt = S_MR2;
      end
      S_MR2: begin
        cmdOut = CMD_LOAD; strb.wordSel = W_MODE;
        if (ctlState == CMD_LOAD) nxt = S_GMR2;
      end
      S_GMR2:  if (ctlIdle) nxt = S_DONE;
      S_DONE:  nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  assign initDone = (state == S_DONE);

  // R9: an unacknowledged request is held
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (rst)
    (cmdOut != CMD_NOP && ctlState != 2'(cmdOut)) |=> (cmdOut == $past(cmdOut)));

  // R10: new request only after an idle controller cycle
  assert_gap_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cmdOut != CMD_NOP && $past(cmdOut) == CMD_NOP) |-> ($past(ctlState) == 2'd0));

  // R11: done is sticky and quiet
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (cmdOut == CMD_NOP));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int       ADDR_W      = 12,
  parameter int       PWR_CYCLES  = 20000,
  parameter int       DLL_CYCLES  = 200,
  parameter int       TRFC_CYCLES = 8,
  parameter bit [2:0] BURST_CODE  = 3'b010,
  parameter bit       BURST_TYPE  = 1'b0,
  parameter bit [2:0] CAS_CODE    = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctlState,
  output logic [1:0]        cmd,
  output logic [1:0]        bank,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  strobe_t strb;
  cmd_e    cmdE;
  logic    pwrDone, dllDone, rfcDone;

  ddr_init_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctlState (ctlState),
    .pwrDone  (pwrDone),
    .dllDone  (dllDone),
    .rfcDone  (rfcDone),
    .cmdOut   (cmdE),
    .strb     (strb),
    .initDone (initDone)
  );

  ddr_init_dp #(
    .ADDR_W      (ADDR_W),
    .PWR_CYCLES  (PWR_CYCLES),
    .DLL_CYCLES  (DLL_CYCLES),
    .TRFC_CYCLES (TRFC_CYCLES),
    .BURST_CODE  (BURST_CODE),
    .BURST_TYPE  (BURST_TYPE),
    .CAS_CODE    (CAS_CODE)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .pwrDone (pwrDone),
    .dllDone (dllDone),
    .rfcDone (rfcDone),
    .bank    (bank),
    .addr    (addr)
  );

  assign cmd = cmdE;

  // R11: NOP carries a zero word
  assert_nop_word_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd0) |-> (bank == 2'd0 && addr == '0));

  // R9: word stable while the same request is held
  assert_word_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd != 2'd0 && $past(cmd) == cmd) |-> ($stable(addr) && $stable(bank)));

endmodule

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

  localparam int       ADDR_W = 12;
  localparam int       PWR    = 40;
  localparam int       DLL    = 30;
  localparam int       TRFC   = 6;
  localparam bit [2:0] BL     = 3'b011;
  localparam bit       BT     = 1'b1;
  localparam bit [2:0] CL     = 3'b010;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        ctlState;
  logic [1:0]        cmd;
  logic [1:0]        bank;
  logic [ADDR_W-1:0] addr;
  logic              initDone;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .PWR_CYCLES(PWR), .DLL_CYCLES(DLL), .TRFC_CYCLES(TRFC),
    .BURST_CODE(BL), .BURST_TYPE(BT), .CAS_CODE(CL)
  ) i_ddr_init_seq (
    .clk(clk), .rst(rst), .ctlState(ctlState),
    .cmd(cmd), .bank(bank), .addr(addr), .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expCmd(input int i);
    case (i)
      0, 3:    return 1;
      1, 2, 6: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int expBank(input int i);
    return (i == 1) ? 1 : 0;
  endfunction

  function automatic int expAddr(input int i);
    int mode;
    mode = (int'(CL) << 4) | (int'(BT) << 3) | int'(BL);
    case (i)
      0, 3:    return 'h400;
      2:       return mode | 'h100;
      6:       return mode;
      default: return 0;
    endcase
  endfunction

  // Controller model: random acceptance delay with wrong codes, random hold
  int         mSt, mDly, mHold;
  logic [1:0] mCmd;
  always @(posedge clk) begin
    if (rst) begin
      mSt <= 0; ctlState <= 2'd0; mDly <= 0; mHold <= 0; mCmd <= 2'd0;
    end else begin
      case (mSt)
        0: begin
          ctlState <= 2'd0;
          if (cmd != 2'd0) begin
            mCmd <= cmd; mDly <= int'($urandom % 3); mSt <= 1;
          end
        end
        1: begin
          if (mDly == 0) begin
            ctlState <= mCmd; mHold <= int'($urandom % 3); mSt <= 2;
          end else begin
            mDly <= mDly - 1;
            // R9: foreign codes while the request waits
            ctlState <= ($urandom % 2 == 1) ? 2'((mCmd % 3) + 1) : 2'd0;
          end
        end
        default: begin
          if (mHold == 0) begin ctlState <= 2'd0; mSt <= 0; end
          else mHold <= mHold - 1;
        end
      endcase
    end
  end

  // Monitor at negedge: record every new request
  int         nCmd, nopRun;
  logic [1:0] prevCmd;
  int         recCmd [8];
  int         recBank[8];
  int         recAddr[8];
  int         nopB   [8];
  always @(negedge clk) begin
    if (rst) begin
      nCmd = 0; nopRun = 0; prevCmd = 2'd0;
    end else begin
      if (cmd != 2'd0 && prevCmd == 2'd0) begin
        chk(ctlState == 2'd0, "R10 controller idle at new request", ctlState, 0);
        if (nCmd < 8) begin
          recCmd[nCmd] = cmd; recBank[nCmd] = bank;
          recAddr[nCmd] = addr; nopB[nCmd] = nopRun;
        end
        nCmd++;
        nopRun = 0;
      end
      if (cmd == 2'd0) nopRun++;
      if (initDone && nCmd < 7)
        chk(1'b0, "R11 done before final load", nCmd, 7);
      prevCmd = cmd;
    end
  end

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cmd == 2'd0,  "R1 cmd after reset",      cmd, 0);
    chk(initDone == 1'b0, "R1 initDone after reset", initDone, 0);
    chk(addr == '0 && bank == 2'd0, "R1 word after reset", addr, 0);
    #1 rst = 1'b0;
  endtask

  task automatic runAndCheck();
    int lim;
    lim = 0;
    while (!initDone && lim < 5000) begin @(negedge clk); lim++; end
    chk(initDone == 1'b1, "R11 watchdog initDone", initDone, 1);
    repeat (30) @(negedge clk);
    chk(nCmd == 7, "R3 command count", nCmd, 7);
    for (int i = 0; i < 7; i++) begin
      chk(recCmd[i] == expCmd(i), "R3 command order", recCmd[i], expCmd(i));
      chk(recBank[i] == expBank(i), "R4/R5/R6 bank word", recBank[i], expBank(i));
      chk(recAddr[i] == expAddr(i), "R4/R5/R6 address word", recAddr[i], expAddr(i));
    end
    chk(nopB[0] == PWR + 1, "R2 power-settle NOP count", nopB[0], PWR + 1);
    chk(nopB[3] == DLL,     "R7 DLL lock NOP count", nopB[3], DLL);
    chk(nopB[5] == TRFC,    "R8 tRFC after first refresh", nopB[5], TRFC);
    chk(nopB[6] == TRFC,    "R8 tRFC after second refresh", nopB[6], TRFC);
    chk(initDone == 1'b1 && cmd == 2'd0, "R11 done sticky and quiet", initDone, 1);
  endtask

  initial begin
    int lim;
    void'($urandom(32'd2024));
    // Run A: plain bring-up
    doReset();
    runAndCheck();
    // Run B: reset in mid-sequence, then full bring-up
    doReset();
    lim = 0;
    while (nCmd < 3 && lim < 5000) begin @(negedge clk); lim++; end
    chk(nCmd >= 3, "R1 watchdog mid-sequence", nCmd, 3);
    doReset();
    runAndCheck();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule